// File: doc/BRIEF.md
# Periodic Battery Check Sequencer

This block decides when a backup battery is measured and keeps the answer. A check is started by a power-up event, and after that by a long free-running interval timer. A check raises a request to an external voltage comparator, waits a fixed number of cycles for that comparator to settle, and then takes a single sample of its "below threshold" result. The sampled result becomes a sticky battery-low status. The status drives the enable of an active-low open-drain pin, so it pulls the pin low while the battery is weak.

Nothing is measured while the main supply is missing. In that state the request is withdrawn, the interval timer is held at zero and power-up events are ignored. The last status is kept. A check that is running when the supply fails is abandoned, and the status stays as it was. The interval is a parameter in clock ticks. It defaults to a full day at a 1 MHz clock and can be set short for simulation.

Top module: `batt_check_seq`

## Requirements
- R1: While and right after reset, `cmp_req` and `low_drive_en` are both 0.
- R2: If `powerup_evt` is 1 at a rising edge while `supply_ok` is 1, `cmp_req` is 1 for exactly SETTLE_CYCLES consecutive cycles, starting in the cycle after that edge.
- R3: The comparator is sampled once, at the edge that ends the last request cycle. From the next cycle `low_drive_en` equals the sampled `cmp_below` (1 = battery below threshold).
- R4: Between checks `low_drive_en` holds its value, whatever `cmp_below` does. A value of 1 means the open-drain pin is driven low.
- R5: While `supply_ok` stays 1, a new check is launched INTERVAL_TICKS cycles after the previous launch. No request is raised in between.
- R6: A power-up check restarts the interval. The next periodic check is launched INTERVAL_TICKS cycles after the power-up launch.
- R7: While `supply_ok` is 0, `cmp_req` is 0, `powerup_evt` has no effect and `low_drive_en` is held.
- R8: If `supply_ok` falls during a check, `cmp_req` is 0 from the next cycle and `low_drive_en` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Main supply at nominal level |
| powerup_evt | input | 1 | One-cycle pulse when main power comes up |
| cmp_below | input | 1 | Comparator result, 1 when battery is below threshold |
| cmp_req | output | 1 | Request to the comparator, high during a check |
| low_drive_en | output | 1 | Pull-down enable of the open-drain battery-low pin |

## Verification
Checks are started both by power-up pulses and by the interval timer, each with a random comparator level. This shows that the status follows the sampled value and not an older one. Between checks the comparator input toggles randomly, which separates a sticky status from one that tracks the input. A power-up issued partway through an interval shows whether the timer really restarts, because a timer that did not restart would fire early. A supply loss during a check, followed by a long unpowered stretch with a power-up pulse in it, separates an aborted check from a completed one, and shows that powered-down events are ignored.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    typedef enum logic [1:0] {
        CHK_IDLE   = 2'd0,
        CHK_SETTLE = 2'd1
    } chk_state_e;

endpackage

// File: rtl/bcs_interval_timer.sv
module bcs_interval_timer #(
    parameter longint unsigned TICKS = 64'd86_400_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic expire
);
    localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_regs_t;

    tmr_regs_t r_d, r_q;

    always_comb begin
        r_d    = r_q;
        expire = run && (r_q.cnt == LAST);
        if (!run) begin
            r_d.cnt = '0;
        end else if (restart || expire) begin
            r_d.cnt = '0;
        end else begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.cnt <= '0;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/bcs_check_fsm.sv
module bcs_check_fsm
    import bcs_pkg::*;
#(
    parameter int SETTLE_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic start_pwr,
    input  logic start_tmr,
    input  logic cmp_below,
    output logic cmp_req,
    output logic batt_low
);
    localparam int SW = $clog2(SETTLE_CYCLES + 1);
    localparam logic [SW-1:0] RELOAD = SW'(SETTLE_CYCLES - 1);

    typedef struct packed {
        chk_state_e    state;
        logic [SW-1:0] wait_cnt;
        logic          low;
    } fsm_regs_t;

    fsm_regs_t r_d, r_q;
    logic      go;

    always_comb begin
        r_d = r_q;
        go  = supply_ok && (start_pwr || ((r_q.state == CHK_IDLE) && start_tmr));
        if (!supply_ok) begin
            r_d.state    = CHK_IDLE;
            r_d.wait_cnt = '0;
        end else if (go) begin
            r_d.state    = CHK_SETTLE;
            r_d.wait_cnt = RELOAD;
        end else if (r_q.state == CHK_SETTLE) begin
            if (r_q.wait_cnt == '0) begin
                r_d.low   = cmp_below;
                r_d.state = CHK_IDLE;
            end else begin
                r_d.wait_cnt = r_q.wait_cnt - 1'b1;
            end
        end
    end

    assign cmp_req  = (r_q.state == CHK_SETTLE);
    assign batt_low = r_q.low;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state    <= CHK_IDLE;
            r_q.wait_cnt <= '0;
            r_q.low      <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/batt_check_seq.sv
module batt_check_seq #(
    parameter longint unsigned INTERVAL_TICKS = 64'd86_400_000_000,
    parameter int              SETTLE_CYCLES  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic powerup_evt,
    input  logic cmp_below,
    output logic cmp_req,
    output logic low_drive_en
);
    logic pwr_start;
    logic tmr_expire;

    assign pwr_start = supply_ok && powerup_evt;

    bcs_interval_timer #(
        .TICKS(INTERVAL_TICKS)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (supply_ok),
        .restart(pwr_start),
        .expire (tmr_expire)
    );

    bcs_check_fsm #(
        .SETTLE_CYCLES(SETTLE_CYCLES)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .supply_ok(supply_ok),
        .start_pwr(pwr_start),
        .start_tmr(tmr_expire),
        .cmp_below(cmp_below),
        .cmp_req  (cmp_req),
        .batt_low (low_drive_en)
    );
endmodule

// File: rtl/bcs_checker.sv
module bcs_checker #(
    parameter int SETTLE_CYCLES = 8
) (
    input logic clk,
    input logic rst_n,
    input logic supply_ok,
    input logic powerup_evt,
    input logic cmp_below,
    input logic cmp_req,
    input logic low_drive_en,
    input logic tmr_expire
);
    int   req_run;
    logic pwr_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_run  <= 0;
            pwr_seen <= 1'b0;
        end else begin
            pwr_seen <= powerup_evt && supply_ok;
            if (!cmp_req)      req_run <= 0;
            else if (pwr_seen) req_run <= 1;
            else               req_run <= req_run + 1;
        end
    end

    // R2: request length never exceeds the settle window
    assert_req_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_run <= SETTLE_CYCLES);

    // R2: a request only starts after a power-up event or timer expiry
    assert_req_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmp_req) |-> ($past(powerup_evt) || $past(tmr_expire)) && $past(supply_ok));

    // R3: status changes only as the result of a finished check, to the sampled level
    assert_status_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(low_drive_en) |-> $past(cmp_req) && $past(supply_ok)
                                   && (low_drive_en == $past(cmp_below)));

    // R5: an idle timer expiry launches a check
    assert_tmr_launch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_expire && supply_ok && !cmp_req) |=> cmp_req);

    // R7 / R8: no request in the cycle after the supply is missing
    assert_no_req_unpowered_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> !cmp_req);
endmodule

bind batt_check_seq bcs_checker #(
    .SETTLE_CYCLES(SETTLE_CYCLES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .supply_ok   (supply_ok),
    .powerup_evt (powerup_evt),
    .cmp_below   (cmp_below),
    .cmp_req     (cmp_req),
    .low_drive_en(low_drive_en),
    .tmr_expire  (tmr_expire)
);

// File: tb/sim_batt_check_seq.sv
module sim_batt_check_seq;
    localparam longint unsigned N = 40;
    localparam int S = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b0;
    logic powerup_evt = 1'b0;
    logic cmp_below = 1'b0;
    logic cmp_req;
    logic low_drive_en;

    int checks = 0;
    int errors = 0;
    bit held = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    batt_check_seq #(.INTERVAL_TICKS(N), .SETTLE_CYCLES(S)) u0 (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .powerup_evt(powerup_evt),
        .cmp_below(cmp_below), .cmp_req(cmp_req), .low_drive_en(low_drive_en)
    );

    function automatic bit exp_status(bit sampled);
        return sampled;
    endfunction

    function automatic int idle_len();
        return int'(N) - S - 1;
    endfunction

    task automatic chk(bit act, bit exp, string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // starts at the negedge before the launch edge has passed; ends S+1 negedges later
    task automatic observe_check(bit cmp, string tag);
        for (int k = 0; k < S; k++) begin
            @(negedge clk);
            powerup_evt = 1'b0;
            chk(cmp_req, 1'b1, {tag, " R2 request window"});
        end
        @(negedge clk);
        chk(cmp_req, 1'b0, {tag, " R2 request ends"});
        chk(low_drive_en, exp_status(cmp), {tag, " R3 status"});
        held = exp_status(cmp);
    endtask

    task automatic launch_pwr(bit cmp, string tag);
        @(negedge clk);
        supply_ok   = 1'b1;
        cmp_below   = cmp;
        powerup_evt = 1'b1;
        observe_check(cmp, tag);
    endtask

    task automatic idle_gap(int n, bit final_cmp, string tag);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            chk(cmp_req, 1'b0, {tag, " R5 no early request"});
            chk(low_drive_en, held, {tag, " R4 status held"});
            cmp_below = (k == n - 1) ? final_cmp : 1'($urandom);
        end
    endtask

    task automatic periodic(bit cmp, string tag);
        idle_gap(idle_len(), cmp, tag);
        observe_check(cmp, tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        chk(cmp_req, 1'b0, "R1 reset request");
        chk(low_drive_en, 1'b0, "R1 reset status");
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmp_req, 1'b0, "R1 after reset request");
        chk(low_drive_en, 1'b0, "R1 after reset status");

        // directed: power-up finds weak battery, then interval checks flip it
        launch_pwr(1'b1, "pwr weak");
        periodic(1'b0, "R5 first interval");
        periodic(1'b1, "R5 second interval");
        periodic(1'b1, "R5 repeat weak");

        // random interval checks
        for (int i = 0; i < 5; i++) begin
            periodic(1'($urandom), "R5 random interval");
        end

        // R6: power-up mid interval restarts the timer
        idle_gap(15, ~held, "R6 partial gap");
        launch_pwr(~held, "R6 restart");
        periodic(~held, "R6 interval from restart");

        // R8: supply loss during a check
        @(negedge clk);
        cmp_below   = ~held;
        powerup_evt = 1'b1;
        @(negedge clk);
        powerup_evt = 1'b0;
        chk(cmp_req, 1'b1, "R8 check started");
        @(negedge clk);
        chk(cmp_req, 1'b1, "R8 check running");
        supply_ok = 1'b0;
        @(negedge clk);
        chk(cmp_req, 1'b0, "R8 request dropped");
        chk(low_drive_en, held, "R8 status unchanged");

        // R7: unpowered stretch with an ignored power-up pulse
        for (int k = 0; k < 2 * int'(N); k++) begin
            powerup_evt = (k == 10);
            cmp_below   = 1'($urandom);
            @(negedge clk);
            chk(cmp_req, 1'b0, "R7 no request unpowered");
            chk(low_drive_en, held, "R7 status held unpowered");
        end
        powerup_evt = 1'b0;

        // back to power with random checks
        for (int i = 0; i < 3; i++) begin
            launch_pwr(1'($urandom), "R2 random power-up");
            periodic(1'($urandom), "R5 after power-up");
        end

        done = 1'b1;
        finish_run();
    end
endmodule